// File: doc/BRIEF.md
# Free-Cell Rotation Scheduler

This block walks one unused logic cell across a rectangular array of logic cells so that every cell in turn is emptied and can be checked without stopping the system. At each step the scheduler asks an external configuration agent to copy the function of the adjacent cell on the walk into the free cell. For a cell that holds state, it also asks for a state-transfer path. It then holds both copies running together for a set number of cycles. Last, it asks a test agent to check the cell that has just been emptied. Every request is a one-cycle strobe answered by a one-cycle done pulse. The scheduler does not start the next request until the current one has been answered.

The walk is a vertical serpentine. Even columns are walked top to bottom, odd columns bottom to top, and each column end steps sideways into the next column. When the last cell is reached the walk turns round and retraces the same path. On its return to the first cell the original placement is restored. The scheduler then carries on or goes idle, depending on a loop input. A pause input holds the walk, but only between steps.

Top module: `rot_sched`

## Requirements
- R1: While reset is high, and in the cycle after it drops, the outputs are as follows. The free cell is row 0, column 0. The neighbour is row 1, column 0. Direction reads 0 (outward). The step count is 0. All command strobes, `dual_run` and `sweep_done` are low.
- R2: The walk uses path index p, with column p / ROWS and offset p % ROWS. The row equals the offset in even columns and ROWS-1-offset in odd columns. The neighbour is at index p+1 while the direction is 0 and at p-1 while it is 1, so the neighbour is always adjacent to the free cell.
- R3: `rep_cmd`, `xfer_cmd` and `tst_cmd` are single-cycle strobes, and at most one is high in any cycle. A done pulse that arrives while the scheduler is not waiting for that particular done has no effect.
- R4: If `cell_seq` is high in the cycle `rep_done` is accepted, `xfer_cmd` is issued next and the overlap waits for `xfer_done`. If `cell_seq` is low, no `xfer_cmd` is issued for that step.
- R5: After replication, and after the transfer when there is one, `dual_run` is high for exactly OVLP_CYC consecutive cycles. `tst_cmd` rises in the cycle `dual_run` falls, and the free cell does not move while `dual_run` is high.
- R6: While `tst_cmd` is high, the neighbour outputs show the cell that is about to become free, and the free-cell outputs are unchanged.
- R7: Two cycles after `tst_done` is accepted, the free cell takes the old neighbour position and the neighbour moves one further along the path.
- R8: When the free cell reaches the last path index, the direction becomes 1. When it gets back to index 0, the direction becomes 0. Each reversal raises `sweep_done` for one cycle, in the same cycle the direction changes.
- R9: `step_cnt` goes up by one with each completed step and returns to 0 when the free cell gets back to index 0.
- R10: On return to index 0, the walk continues if `loop_en` is high at that moment. Otherwise it goes idle. In idle no command is issued until `start` is seen.
- R11: `pause` is only acted on between steps. While it is high there, no `rep_cmd` is issued. Raising it during a step does not stop that step's commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leaves idle and begins walking |
| pause | input | 1 | Holds the walk at the next step boundary |
| loop_en | input | 1 | Keep walking after a full rotation |
| cell_seq | input | 1 | Cell being copied holds state; sampled with rep_done |
| rep_done | input | 1 | Replication finished |
| xfer_done | input | 1 | State transfer and shared clock finished |
| tst_done | input | 1 | Test of the freed cell finished |
| rep_cmd | output | 1 | Request: copy neighbour into free cell |
| xfer_cmd | output | 1 | Request: state-transfer path plus shared clock pulse |
| tst_cmd | output | 1 | Request: test the cell shown on the neighbour outputs |
| dual_run | output | 1 | Original and copy run side by side |
| free_row | output | $clog2(ROWS) | Row of the free cell |
| free_col | output | $clog2(COLS) | Column of the free cell |
| nbr_row | output | $clog2(ROWS) | Row of the cell to be copied next |
| nbr_col | output | $clog2(COLS) | Column of the cell to be copied next |
| dir_back | output | 1 | 0 walking outward, 1 walking back |
| sweep_done | output | 1 | One-cycle pulse at each reversal |
| step_cnt | output | $clog2(2*ROWS*COLS) | Completed steps since last restore |

## Verification
A wrong walker state shows up on the coordinate outputs within two cycles of the test-done pulse, either as a cell that is not adjacent or as one that is not on the serpentine path. The same state also drives a wrong reversal, which appears as a misplaced sweep pulse, and that shows at the latest at the end of the sweep. A wrong sequencer state shows up on the strobes. It can appear as an extra or missing transfer request, as an overlap window of the wrong length, or as a request issued before its done, and it appears in the same step it occurs in. A counter fault appears as a mismatch at the next replication request.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOUND,
    ST_REPL,
    ST_XFER,
    ST_OVLP,
    ST_TEST,
    ST_ADV
  } rot_state_e;

endpackage

// File: rtl/rot_walker.sv
module rot_walker #(
  parameter int ROWS = 28,
  parameter int COLS = 42,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [RW-1:0] free_row,
  output logic [CW-1:0] free_col,
  output logic [RW-1:0] nbr_row,
  output logic [CW-1:0] nbr_col,
  output logic          dir_back,
  output logic          sweep_end,
  output logic          last_move
);

  localparam logic [RW-1:0] ROW_END = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_END = CW'(COLS - 1);
  localparam logic [RW-1:0] FAR_ROW = (COLS % 2 == 1) ? RW'(ROWS - 1) : '0;

  // One move along the serpentine from (r,c) in the given direction.
  function automatic logic [RW+CW-1:0] step_of(input logic [RW-1:0] r,
                                               input logic [CW-1:0] c,
                                               input logic back);
    logic          down;
    logic [RW-1:0] nr;
    logic [CW-1:0] nc;
    down = ~(c[0] ^ back);
    nr   = r;
    nc   = c;
    if (down) begin
      if (r != ROW_END) nr = r + 1'b1;
      else              nc = back ? c - 1'b1 : c + 1'b1;
    end else begin
      if (r != '0) nr = r - 1'b1;
      else         nc = back ? c - 1'b1 : c + 1'b1;
    end
    return {nr, nc};
  endfunction

  logic hit_far;
  logic hit_home;
  logic new_back;

  always_comb begin
    hit_far   = !dir_back && (nbr_col == COL_END) && (nbr_row == FAR_ROW);
    hit_home  = dir_back && (nbr_col == '0) && (nbr_row == '0);
    new_back  = dir_back ^ (hit_far | hit_home);
    last_move = hit_home;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_row             <= '0;
      free_col             <= '0;
      dir_back             <= 1'b0;
      sweep_end            <= 1'b0;
      {nbr_row, nbr_col}   <= step_of('0, '0, 1'b0);
    end else begin
      sweep_end <= 1'b0;
      if (adv) begin
        free_row           <= nbr_row;
        free_col           <= nbr_col;
        dir_back           <= new_back;
        sweep_end          <= hit_far | hit_home;
        {nbr_row, nbr_col} <= step_of(nbr_row, nbr_col, new_back);
      end
    end
  end

endmodule

// File: rtl/rot_step_ctl.sv
module rot_step_ctl
  import rot_pkg::*;
#(
  parameter int OVLP_CYC = 1,
  localparam int OW = $clog2(OVLP_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pause,
  input  logic loop_en,
  input  logic cell_seq,
  input  logic rep_done,
  input  logic xfer_done,
  input  logic tst_done,
  input  logic last_move,
  output logic rep_cmd,
  output logic xfer_cmd,
  output logic tst_cmd,
  output logic dual_run,
  output logic adv
);

  localparam logic [OW-1:0] OV_LAST = OW'(OVLP_CYC - 1);

  rot_state_e    state;
  logic [OW-1:0] ov_cnt;

  assign adv = (state == ST_ADV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rep_cmd  <= 1'b0;
      xfer_cmd <= 1'b0;
      tst_cmd  <= 1'b0;
      dual_run <= 1'b0;
      ov_cnt   <= '0;
    end else begin
      rep_cmd  <= 1'b0;
      xfer_cmd <= 1'b0;
      tst_cmd  <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_BOUND;
        ST_BOUND: begin
          if (!pause) begin
            rep_cmd <= 1'b1;
            state   <= ST_REPL;
          end
        end
        ST_REPL: begin
          if (rep_done) begin
            if (cell_seq) begin
              xfer_cmd <= 1'b1;
              state    <= ST_XFER;
            end else begin
              dual_run <= 1'b1;
              ov_cnt   <= '0;
              state    <= ST_OVLP;
            end
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            dual_run <= 1'b1;
            ov_cnt   <= '0;
            state    <= ST_OVLP;
          end
        end
        ST_OVLP: begin
          if (ov_cnt == OV_LAST) begin
            dual_run <= 1'b0;
            tst_cmd  <= 1'b1;
            state    <= ST_TEST;
          end else begin
            ov_cnt <= ov_cnt + 1'b1;
          end
        end
        ST_TEST: if (tst_done) state <= ST_ADV;
        ST_ADV:  state <= (last_move && !loop_en) ? ST_IDLE : ST_BOUND;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rot_step_count.sv
module rot_step_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             last_move,
  output logic [CNT_W-1:0] step_cnt
);

  always_ff @(posedge clk) begin
    if (rst)      step_cnt <= '0;
    else if (adv) step_cnt <= last_move ? '0 : step_cnt + 1'b1;
  end

endmodule

// File: rtl/rot_sched.sv
module rot_sched #(
  parameter int ROWS     = 28,
  parameter int COLS     = 42,
  parameter int OVLP_CYC = 1,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int CNT_W = $clog2(2 * ROWS * COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pause,
  input  logic             loop_en,
  input  logic             cell_seq,
  input  logic             rep_done,
  input  logic             xfer_done,
  input  logic             tst_done,
  output logic             rep_cmd,
  output logic             xfer_cmd,
  output logic             tst_cmd,
  output logic             dual_run,
  output logic [RW-1:0]    free_row,
  output logic [CW-1:0]    free_col,
  output logic [RW-1:0]    nbr_row,
  output logic [CW-1:0]    nbr_col,
  output logic             dir_back,
  output logic             sweep_done,
  output logic [CNT_W-1:0] step_cnt
);

  logic adv;
  logic last_move;

  rot_step_ctl #(.OVLP_CYC(OVLP_CYC)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .pause(pause), .loop_en(loop_en),
    .cell_seq(cell_seq), .rep_done(rep_done), .xfer_done(xfer_done),
    .tst_done(tst_done), .last_move(last_move), .rep_cmd(rep_cmd),
    .xfer_cmd(xfer_cmd), .tst_cmd(tst_cmd), .dual_run(dual_run), .adv(adv)
  );

  rot_walker #(.ROWS(ROWS), .COLS(COLS)) u_walk (
    .clk(clk), .rst(rst), .adv(adv), .free_row(free_row), .free_col(free_col),
    .nbr_row(nbr_row), .nbr_col(nbr_col), .dir_back(dir_back),
    .sweep_end(sweep_done), .last_move(last_move)
  );

  rot_step_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .last_move(last_move), .step_cnt(step_cnt)
  );

endmodule

// File: rtl/rot_sched_chk.sv
module rot_sched_chk #(
  parameter int ROWS     = 28,
  parameter int COLS     = 42,
  parameter int OVLP_CYC = 1,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int CNT_W = $clog2(2 * ROWS * COLS)
) (
  input logic             clk,
  input logic             rst,
  input logic             rep_cmd,
  input logic             xfer_cmd,
  input logic             tst_cmd,
  input logic             dual_run,
  input logic [RW-1:0]    free_row,
  input logic [CW-1:0]    free_col,
  input logic [RW-1:0]    nbr_row,
  input logic [CW-1:0]    nbr_col,
  input logic             dir_back,
  input logic             sweep_done,
  input logic [CNT_W-1:0] step_cnt
);

  int  dr;
  int  dc;
  logic adj_ok;

  always_comb begin
    dr     = (free_row > nbr_row) ? int'(free_row - nbr_row) : int'(nbr_row - free_row);
    dc     = (free_col > nbr_col) ? int'(free_col - nbr_col) : int'(nbr_col - free_col);
    adj_ok = (dr + dc) == 1;
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0({rep_cmd, xfer_cmd, tst_cmd})); // R3
  AST_REP_PULSE: assert property (@(posedge clk) disable iff (rst) rep_cmd |=> !rep_cmd); // R3
  AST_TST_PULSE: assert property (@(posedge clk) disable iff (rst) tst_cmd |=> !tst_cmd); // R3
  AST_NBR_ADJ: assert property (@(posedge clk) disable iff (rst) adj_ok); // R2
  AST_OVLP_STILL: assert property (@(posedge clk) disable iff (rst) dual_run |=> $stable(free_row) && $stable(free_col)); // R5
  AST_OVLP_TO_TEST: assert property (@(posedge clk) disable iff (rst) $fell(dual_run) |-> tst_cmd); // R5
  AST_SWEEP_FLIP: assert property (@(posedge clk) disable iff (rst) sweep_done |-> dir_back != $past(dir_back)); // R8
  AST_MOVE_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (free_row != $past(free_row) || free_col != $past(free_col)) |-> step_cnt != $past(step_cnt)); // R9

endmodule

bind rot_sched rot_sched_chk #(.ROWS(ROWS), .COLS(COLS), .OVLP_CYC(OVLP_CYC)) u_chk (
  .clk(clk), .rst(rst), .rep_cmd(rep_cmd), .xfer_cmd(xfer_cmd), .tst_cmd(tst_cmd),
  .dual_run(dual_run), .free_row(free_row), .free_col(free_col), .nbr_row(nbr_row),
  .nbr_col(nbr_col), .dir_back(dir_back), .sweep_done(sweep_done), .step_cnt(step_cnt)
);

// File: tb/sim_rot_sched.sv
module sim_rot_sched;

  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int OVLP = 2;
  localparam int N    = ROWS * COLS;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int CNTW = $clog2(2 * ROWS * COLS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, pause = 0, loop_en = 0, cell_seq = 0;
  logic rep_done = 0, xfer_done = 0, tst_done = 0;
  logic rep_cmd, xfer_cmd, tst_cmd, dual_run, dir_back, sweep_done;
  logic [RW-1:0] free_row, nbr_row;
  logic [CW-1:0] free_col, nbr_col;
  logic [CNTW-1:0] step_cnt;

  int errs = 0;
  int checks = 0;
  int p = 0;
  int edir = 0;
  int ecnt = 0;

  always #2.5 clk = ~clk;

  rot_sched #(.ROWS(ROWS), .COLS(COLS), .OVLP_CYC(OVLP)) u0 (
    .clk(clk), .rst(rst), .start(start), .pause(pause), .loop_en(loop_en),
    .cell_seq(cell_seq), .rep_done(rep_done), .xfer_done(xfer_done), .tst_done(tst_done),
    .rep_cmd(rep_cmd), .xfer_cmd(xfer_cmd), .tst_cmd(tst_cmd), .dual_run(dual_run),
    .free_row(free_row), .free_col(free_col), .nbr_row(nbr_row), .nbr_col(nbr_col),
    .dir_back(dir_back), .sweep_done(sweep_done), .step_cnt(step_cnt)
  );

  function automatic int row_of(input int idx);
    int c = idx / ROWS;
    int o = idx % ROWS;
    return (c % 2 == 0) ? o : ROWS - 1 - o;
  endfunction

  function automatic int col_of(input int idx);
    return idx / ROWS;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic dly(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cmd(input int which, output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if ((which == 0 && rep_cmd) || (which == 1 && xfer_cmd) || (which == 2 && tst_cmd)) begin
        got = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_step(input bit seq, input bit stray, input bit pmid);
    bit got;
    int np;
    int dcnt;
    int xbad;
    np = (edir == 0) ? p + 1 : p - 1;
    wait_cmd(0, got);
    chk("R3 rep_cmd issued", int'(got), 1);
    chk("R2 free row", int'(free_row), row_of(p));
    chk("R2 free col", int'(free_col), col_of(p));
    chk("R2 nbr row", int'(nbr_row), row_of(np));
    chk("R2 nbr col", int'(nbr_col), col_of(np));
    chk("R9 step count", int'(step_cnt), ecnt);
    if (pmid) pause = 1'b1;
    @(negedge clk);
    chk("R3 rep_cmd single cycle", int'(rep_cmd), 0);
    if (stray) begin
      tst_done = 1'b1;
      xfer_done = 1'b1;
      @(negedge clk);
      tst_done = 1'b0;
      xfer_done = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chk("R3 stray done ignored", int'(tst_cmd | xfer_cmd | dual_run), 0);
        @(negedge clk);
      end
    end
    dly($urandom % 4);
    rep_done = 1'b1;
    cell_seq = seq;
    @(negedge clk);
    rep_done = 1'b0;
    cell_seq = 1'b0;
    if (seq) begin
      wait_cmd(1, got);
      chk("R4 xfer_cmd for stateful cell", int'(got), 1);
      dly($urandom % 3);
      chk("R4 no overlap before transfer done", int'(dual_run), 0);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
    end
    dcnt = 0;
    xbad = 0;
    for (int i = 0; i < 40; i++) begin
      if (tst_cmd) break;
      if (dual_run) dcnt++;
      if (xfer_cmd) xbad++;
      @(negedge clk);
    end
    chk("R5 overlap length", dcnt, OVLP);
    if (!seq) chk("R4 no xfer for stateless cell", xbad, 0);
    chk("R5 test strobe follows overlap", int'(tst_cmd), 1);
    chk("R6 test target row", int'(nbr_row), row_of(np));
    chk("R6 test target col", int'(nbr_col), col_of(np));
    chk("R6 free unchanged at test", int'(free_row), row_of(p));
    dly($urandom % 4);
    tst_done = 1'b1;
    @(negedge clk);
    tst_done = 1'b0;
    @(negedge clk);
    p = np;
    if (edir == 0 && p == N - 1) begin
      edir = 1;
      chk("R8 sweep pulse at far end", int'(sweep_done), 1);
    end else if (edir == 1 && p == 0) begin
      edir = 0;
      chk("R8 sweep pulse at origin", int'(sweep_done), 1);
    end else begin
      chk("R8 no sweep pulse mid-walk", int'(sweep_done), 0);
    end
    ecnt = (p == 0) ? 0 : ecnt + 1;
    chk("R7 free row advanced", int'(free_row), row_of(p));
    chk("R7 free col advanced", int'(free_col), col_of(p));
    chk("R8 direction", int'(dir_back), edir);
    chk("R9 count after step", int'(step_cnt), ecnt);
    if (pmid) begin
      xbad = 0;
      for (int i = 0; i < 6; i++) begin
        if (rep_cmd) xbad++;
        @(negedge clk);
      end
      chk("R11 pause held at boundary", xbad, 0);
      pause = 1'b0;
    end
  endtask

  initial begin
    int quiet;
    void'($urandom(32'd2024));
    dly(3);
    chk("R1 free row reset", int'(free_row), 0);
    chk("R1 nbr row reset", int'(nbr_row), 1);
    chk("R1 strobes reset", int'(rep_cmd | xfer_cmd | tst_cmd | dual_run | sweep_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 free col after reset", int'(free_col), 0);
    chk("R1 nbr col after reset", int'(nbr_col), 0);
    chk("R1 dir after reset", int'(dir_back), 0);
    chk("R1 count after reset", int'(step_cnt), 0);
    quiet = 0;
    for (int i = 0; i < 6; i++) begin
      if (rep_cmd) quiet++;
      @(negedge clk);
    end
    chk("R10 idle without start", quiet, 0);

    loop_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do_step(1'b1, 1'b1, 1'b0);
    do_step(1'b0, 1'b1, 1'b1);
    for (int i = 2; i < 2 * (N - 1); i++)
      do_step(1'($urandom % 2), (i % 5) == 0, (i % 7) == 3);

    loop_en = 1'b0;
    for (int i = 0; i < 2 * (N - 1); i++)
      do_step(1'($urandom % 2), (i % 6) == 1, (i % 9) == 4);
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      if (rep_cmd) quiet++;
      @(negedge clk);
    end
    chk("R10 idle after rotation without loop", quiet, 0);
    chk("R10 placement restored row", int'(free_row), 0);
    chk("R10 placement restored col", int'(free_col), 0);
    chk("R9 count cleared on restore", int'(step_cnt), 0);

    pause = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    quiet = 0;
    for (int i = 0; i < 8; i++) begin
      if (rep_cmd) quiet++;
      @(negedge clk);
    end
    chk("R11 pause before first step", quiet, 0);
    pause = 1'b0;
    for (int i = 0; i < 3; i++) do_step(1'(i % 2), 1'b0, 1'b0);
    finish_run();
  end

endmodule